// File: doc/BRIEF.md
# SIMT Divergence Mask Controller

This block owns the active-lane mask of one 32-lane warp while the warp walks through conditional branches. Each lane corresponds to one thread; a thread's lane number is its thread index modulo 32, and bit *i* of every lane vector in this block belongs to lane *i*. When a branch is reported together with a per-lane condition vector, the controller decides whether the active lanes agree. If they agree, the warp follows a single path. If they disagree, the warp first runs the taken path with only the agreeing lanes enabled. It then runs the fall-through path with the remaining lanes enabled, and finally resumes with the pre-branch mask at the reconvergence address.

The path choices are kept on a small stack of frames, so branches can nest. Each frame holds the reconvergence address, the mask to restore, the fall-through address and mask still to run, and a flag showing whether that second path is still pending. Because the two halves run one after the other, a divergent branch costs the sum of its path lengths: a 10-instruction taken side plus a 30-instruction fall-through side costs 40 steps before the full mask returns. The controller drives the fetch address and the current mask to the front end. It also reports the active-lane count as a utilization measure, a one-cycle split indicator, and a sticky overflow error.

Top module: `simt_mask_ctrl`

## Requirements
- R1: After reset the mask, fetch PC, split flag, overflow flag and lane count are all zero and the frame stack is empty.
- R2: A launch loads the mask and fetch PC from the launch inputs, empties the stack and clears the overflow flag; it takes precedence over a step in the same cycle.
- R3: A step without a branch advances the fetch PC by 4 and leaves the mask unchanged.
- R4: A branch step on which every active lane has its condition bit set moves the PC to the branch target; one on which no active lane has it set moves the PC to PC+4. In both cases the mask is unchanged, nothing is pushed, the split flag stays low, and condition bits of inactive lanes have no effect.
- R5: A branch step on which the active lanes disagree pushes a frame, sets the mask to (mask AND condition), moves the PC to the target, and raises the split flag for exactly one cycle; a lane that was inactive is never activated.
- R6: The first time a step's next PC equals the top frame's reconvergence PC, the PC becomes the saved fall-through address (branch PC+4) and the mask becomes (pre-branch mask AND NOT condition); the frame stays on the stack.
- R7: The second time the reconvergence PC is reached, the pre-branch mask is restored, the PC equals the reconvergence PC and the frame is popped, so a 10-step taken path and a 30-step fall-through path return the full mask exactly 40 steps after the branch.
- R8: Up to 8 frames nest; a divergent branch with 8 frames held sets a sticky overflow flag, pushes nothing, keeps the mask and advances the PC by 4.
- R9: The lane-count output equals the number of set bits in the current mask, e.g. 4 for a mask of 0x0000000F.
- R10: A uniform branch whose resulting PC equals the top frame's reconvergence PC performs the reconvergence action of R6 or R7 in the same cycle; a divergent branch never performs one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_i | input | 1 | Start the warp with a new mask and PC |
| launch_mask_i | input | 32 | Initial active-lane mask |
| launch_pc_i | input | 32 | Initial fetch PC |
| step_i | input | 1 | The instruction at the current PC has been issued |
| br_i | input | 1 | The stepped instruction is a conditional branch |
| br_cond_i | input | 32 | Per-lane branch condition, bit i for lane i |
| br_tgt_i | input | 32 | Branch target PC |
| br_join_i | input | 32 | Reconvergence PC of the branch |
| mask_o | output | 32 | Current active-lane mask |
| pc_o | output | 32 | PC to fetch next |
| split_o | output | 1 | The previous cycle's branch enabled lanes on both sides |
| active_cnt_o | output | 6 | Number of active lanes |
| ovf_o | output | 1 | Sticky stack-overflow error |

## Verification
Two functions can fall on the same step: branch resolution and reconvergence. A uniform branch whose target is the enclosing frame's reconvergence PC must switch to the pending fall-through path, or pop, in the same cycle. The bench provokes this from inside a taken path and also issues a launch in the same cycle as a divergent branch. A behavioural model holding a queue of frames predicts mask, PC, split, overflow and lane count after every edge. The outputs are compared with it every cycle, so a collision handled in the wrong order shows up as a PC or mask mismatch on the very next cycle.

// File: rtl/simt_pkg.sv
package simt_pkg;
  parameter int unsigned LANES   = 32;
  parameter int unsigned PC_W    = 32;
  parameter int unsigned PC_STEP = 4;
  localparam int unsigned CNT_W  = $clog2(LANES + 1);

  typedef logic [LANES-1:0] lmask_t;
  typedef logic [PC_W-1:0]  pc_t;

  // One nesting level of divergence bookkeeping.
  typedef struct packed {
    pc_t    join_pc;
    lmask_t saved;
    pc_t    else_pc;
    lmask_t else_m;
    logic   pend;
  } frame_t;

  typedef enum logic [1:0] {
    BR_ALL   = 2'd0,
    BR_NONE  = 2'd1,
    BR_SPLIT = 2'd2
  } br_kind_t;
endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval
  import simt_pkg::*;
(
  input  lmask_t   mask_i,
  input  lmask_t   cond_i,
  output br_kind_t kind_o,
  output lmask_t   taken_o,
  output lmask_t   else_o
);
  // Lanes already off stay off on both sides.
  assign taken_o = mask_i & cond_i;
  assign else_o  = mask_i & ~cond_i;

  always_comb begin
    if (taken_o == mask_i) begin
      kind_o = BR_ALL;
    end else if (taken_o == '0) begin
      kind_o = BR_NONE;
    end else begin
      kind_o = BR_SPLIT;
    end
  end

  always_comb begin
    if (kind_o == BR_SPLIT) begin
      a_split_sides_r5: assert ((taken_o != '0) && (else_o != '0) && ((taken_o | else_o) == mask_i));
    end
  end
endmodule

// File: rtl/simt_lane_count.sv
module simt_lane_count
  import simt_pkg::*;
(
  input  lmask_t           mask_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned GRP  = 4;
  localparam int unsigned NGRP = LANES / GRP;
  localparam int unsigned GW   = $clog2(GRP + 1);

  logic [NGRP*GW-1:0] part_flat;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GW-1:0] sub;
    always_comb begin
      sub = '0;
      for (int b = 0; b < GRP; b++) begin
        sub = sub + GW'(mask_i[g*GRP + b]);
      end
    end
    assign part_flat[g*GW +: GW] = sub;
  end

  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < NGRP; k++) begin
      cnt_o = cnt_o + CNT_W'(part_flat[k*GW +: GW]);
    end
  end
endmodule

// File: rtl/simt_frame_stack.sv
module simt_frame_stack
  import simt_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_i,
  input  logic   push_i,
  input  frame_t frame_i,
  input  logic   pop_i,
  input  logic   clr_pend_i,
  output frame_t top_o,
  output logic   empty_o,
  output logic   full_o
);
  localparam int unsigned SP_W = $clog2(DEPTH + 1);
  localparam int unsigned IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0] sp_q, sp_d;
  logic [IX_W-1:0] top_ix;
  frame_t          slot_q [DEPTH];

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign top_ix  = empty_o ? '0 : IX_W'(sp_q - 1'b1);
  assign top_o   = slot_q[top_ix];

  always_comb begin
    sp_d = sp_q;
    if (clr_i) begin
      sp_d = '0;
    end else if (push_i) begin
      sp_d = sp_q + 1'b1;
    end else if (pop_i) begin
      sp_d = sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else begin
      sp_q <= sp_d;
    end
  end

  // Storage carries no reset; the pointer guards every read.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!clr_i && push_i && (sp_q == SP_W'(i))) begin
        slot_q[i] <= frame_i;
      end else if (!clr_i && clr_pend_i && (sp_q == SP_W'(i + 1))) begin
        slot_q[i].pend <= 1'b0;
      end
    end
  end

  p_push_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i) |-> !full_o);

  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pop_i || clr_pend_i) && !clr_i) |-> !empty_o);

  p_one_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({push_i, pop_i, clr_pend_i}) <= 1);

  p_pop_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !clr_i) |=> (sp_q == $past(sp_q) - 1'b1));
endmodule

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl
  import simt_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [LANES-1:0]  launch_mask_i,
  input  logic [PC_W-1:0]   launch_pc_i,
  input  logic              step_i,
  input  logic              br_i,
  input  logic [LANES-1:0]  br_cond_i,
  input  logic [PC_W-1:0]   br_tgt_i,
  input  logic [PC_W-1:0]   br_join_i,
  output logic [LANES-1:0]  mask_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              split_o,
  output logic [CNT_W-1:0]  active_cnt_o,
  output logic              ovf_o
);
  lmask_t   mask_q, mask_d;
  pc_t      pc_q, pc_d;
  logic     split_q, split_d;
  logic     err_q, err_d;

  br_kind_t kind;
  lmask_t   taken_m, else_m;
  pc_t      seq_pc, cand_pc;
  logic     took_push;

  logic     stk_clr, stk_push, stk_pop, stk_clrp;
  logic     stk_empty, stk_full;
  frame_t   push_frame, top_frame;

  simt_branch_eval u_eval (
    .mask_i  (mask_q),
    .cond_i  (br_cond_i),
    .kind_o  (kind),
    .taken_o (taken_m),
    .else_o  (else_m)
  );

  simt_frame_stack #(.DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (stk_clr),
    .push_i     (stk_push),
    .frame_i    (push_frame),
    .pop_i      (stk_pop),
    .clr_pend_i (stk_clrp),
    .top_o      (top_frame),
    .empty_o    (stk_empty),
    .full_o     (stk_full)
  );

  simt_lane_count u_count (
    .mask_i (mask_q),
    .cnt_o  (active_cnt_o)
  );

  assign seq_pc = pc_q + pc_t'(PC_STEP);

  always_comb begin
    push_frame.join_pc = br_join_i;
    push_frame.saved   = mask_q;
    push_frame.else_pc = seq_pc;
    push_frame.else_m  = else_m;
    push_frame.pend    = 1'b1;
  end

  // Next-state: launch, then branch resolution, then reconvergence.
  always_comb begin
    mask_d    = mask_q;
    pc_d      = pc_q;
    split_d   = 1'b0;
    err_d     = err_q;
    stk_clr   = 1'b0;
    stk_push  = 1'b0;
    stk_pop   = 1'b0;
    stk_clrp  = 1'b0;
    cand_pc   = seq_pc;
    took_push = 1'b0;
    if (launch_i) begin
      mask_d  = launch_mask_i;
      pc_d    = launch_pc_i;
      err_d   = 1'b0;
      stk_clr = 1'b1;
    end else if (step_i) begin
      if (br_i) begin
        case (kind)
          BR_ALL: begin
            cand_pc = br_tgt_i;
          end
          BR_SPLIT: begin
            if (stk_full) begin
              err_d = 1'b1;
            end else begin
              stk_push  = 1'b1;
              took_push = 1'b1;
              mask_d    = taken_m;
              pc_d      = br_tgt_i;
              split_d   = 1'b1;
            end
          end
          default: begin
            cand_pc = seq_pc;
          end
        endcase
      end
      if (!took_push) begin
        if (!stk_empty && (cand_pc == top_frame.join_pc)) begin
          if (top_frame.pend) begin
            mask_d   = top_frame.else_m;
            pc_d     = top_frame.else_pc;
            stk_clrp = 1'b1;
          end else begin
            mask_d  = top_frame.saved;
            pc_d    = top_frame.join_pc;
            stk_pop = 1'b1;
          end
        end else begin
          pc_d = cand_pc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      pc_q    <= '0;
      split_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      pc_q    <= pc_d;
      split_q <= split_d;
      err_q   <= err_d;
    end
  end

  assign mask_o  = mask_q;
  assign pc_o    = pc_q;
  assign split_o = split_q;
  assign ovf_o   = err_q;

  p_launch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> (mask_q == $past(launch_mask_i)) && (pc_q == $past(launch_pc_i)) && !err_q);

  p_uniform_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && br_i && !launch_i && (kind != BR_SPLIT) && stk_empty) |=>
      (mask_q == $past(mask_q)) && !split_q);

  p_split_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    split_q |-> ((mask_q & ~$past(mask_q)) == '0) && (mask_q != '0) && (mask_q != $past(mask_q)));

  p_split_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    split_q |=> (!split_q || $past(step_i && br_i)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !launch_i) |=> err_q);

  p_cnt_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active_cnt_o == CNT_W'($countones(mask_q)));
endmodule

// File: tb/simt_mask_ctrl_tb_top.sv
`timescale 1ns/1ps
module simt_mask_ctrl_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch_i = 1'b0;
  logic [31:0] launch_mask_i = '0;
  logic [31:0] launch_pc_i = '0;
  logic        step_i = 1'b0;
  logic        br_i = 1'b0;
  logic [31:0] br_cond_i = '0;
  logic [31:0] br_tgt_i = '0;
  logic [31:0] br_join_i = '0;
  logic [31:0] mask_o;
  logic [31:0] pc_o;
  logic        split_o;
  logic [5:0]  active_cnt_o;
  logic        ovf_o;

  int n_run = 0;
  int n_fail = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  simt_mask_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .launch_i(launch_i), .launch_mask_i(launch_mask_i), .launch_pc_i(launch_pc_i),
    .step_i(step_i), .br_i(br_i), .br_cond_i(br_cond_i),
    .br_tgt_i(br_tgt_i), .br_join_i(br_join_i),
    .mask_o(mask_o), .pc_o(pc_o), .split_o(split_o),
    .active_cnt_o(active_cnt_o), .ovf_o(ovf_o)
  );

  // Behavioural reference model
  typedef struct {
    logic [31:0] jp;
    logic [31:0] sm;
    logic [31:0] ep;
    logic [31:0] em;
    bit          pend;
  } ent_t;
  ent_t stk[$];
  logic [31:0] m_mask = '0;
  logic [31:0] m_pc = '0;
  bit          m_split = 0;
  bit          m_err = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '0; m_pc = '0; m_split = 0; m_err = 0;
      stk.delete();
    end else begin
      m_split = 0;
      if (launch_i) begin
        m_mask = launch_mask_i; m_pc = launch_pc_i; m_err = 0;
        stk.delete();
      end else if (step_i) begin
        logic [31:0] cand;
        logic [31:0] tk;
        bit pushed;
        cand = m_pc + 32'd4;
        pushed = 0;
        if (br_i) begin
          tk = m_mask & br_cond_i;
          if (tk == m_mask) cand = br_tgt_i;
          else if (tk == 0) cand = m_pc + 32'd4;
          else if (stk.size() >= DEPTH) m_err = 1;
          else begin
            ent_t e;
            e.jp = br_join_i; e.sm = m_mask; e.ep = m_pc + 32'd4;
            e.em = m_mask & ~br_cond_i; e.pend = 1;
            stk.push_back(e);
            m_mask = tk; m_pc = br_tgt_i; m_split = 1; pushed = 1;
          end
        end
        if (!pushed) begin
          if (stk.size() > 0 && cand == stk[stk.size()-1].jp) begin
            int t;
            t = stk.size() - 1;
            if (stk[t].pend) begin
              m_mask = stk[t].em; m_pc = stk[t].ep; stk[t].pend = 0;
            end else begin
              m_mask = stk[t].sm; m_pc = stk[t].jp;
              void'(stk.pop_back());
            end
          end else begin
            m_pc = cand;
          end
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_req, "mask", mask_o, m_mask);
    chk(cur_req, "pc", pc_o, m_pc);
    chk(cur_req, "split", {31'd0, split_o}, {31'd0, m_split});
    chk(cur_req, "ovf", {31'd0, ovf_o}, {31'd0, m_err});
    chk("R9", "lane count", {26'd0, active_cnt_o}, $countones(m_mask));
  endtask

  // Drive at negedge, let one edge pass, compare at the next negedge.
  task automatic cyc(bit ln, logic [31:0] lm, logic [31:0] lp,
                     bit st, bit br, logic [31:0] cd, logic [31:0] tg, logic [31:0] jn);
    launch_i = ln; launch_mask_i = lm; launch_pc_i = lp;
    step_i = st; br_i = br; br_cond_i = cd; br_tgt_i = tg; br_join_i = jn;
    @(posedge clk);
    @(negedge clk);
    compare();
    launch_i = 0; step_i = 0; br_i = 0;
  endtask

  task automatic launch(logic [31:0] lm, logic [31:0] lp);
    cyc(1, lm, lp, 0, 0, '0, '0, '0);
  endtask
  task automatic step();
    cyc(0, '0, '0, 1, 0, '0, '0, '0);
  endtask
  task automatic branch(logic [31:0] cd, logic [31:0] tg, logic [31:0] jn);
    cyc(0, '0, '0, 1, 1, cd, tg, jn);
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int first_full;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    chk("R1", "reset pc", pc_o, 32'd0);
    chk("R1", "reset mask", mask_o, 32'd0);

    // Partial warp and sequential steps
    cur_req = "R2";
    launch(32'h0000_000F, 32'h0000_0040);
    chk("R9", "partial warp count", {26'd0, active_cnt_o}, 32'd4);
    cur_req = "R3";
    step(); step();
    chk("R3", "pc after two steps", pc_o, 32'h48);

    // Uniform branches; inactive lane condition bits must not matter
    cur_req = "R4";
    branch(32'hFFFF_FFF0, 32'h0000_0200, 32'h0000_0300);
    chk("R4", "none-taken pc", pc_o, 32'h4C);
    chk("R4", "none-taken mask", mask_o, 32'hF);
    branch(32'hF000_000F, 32'h0000_0200, 32'h0000_0300);
    chk("R4", "all-taken pc", pc_o, 32'h200);
    chk("R4", "no split on uniform", {31'd0, split_o}, 32'd0);

    // Divergence with 10-step taken path and 30-step fall-through path
    cur_req = "R5";
    launch(32'hFFFF_FFFF, 32'h0000_0100);
    branch(32'h0000_FFFF, 32'h0000_0154, 32'h0000_017C);
    chk("R5", "taken mask", mask_o, 32'h0000_FFFF);
    chk("R5", "split pulse", {31'd0, split_o}, 32'd1);
    first_full = 0;
    for (int i = 1; i <= 40; i++) begin
      cur_req = (i <= 10) ? "R6" : "R7";
      step();
      if (i == 1) chk("R5", "split one cycle", {31'd0, split_o}, 32'd0);
      if (i == 10) begin
        chk("R6", "else pc", pc_o, 32'h104);
        chk("R6", "else mask", mask_o, 32'hFFFF_0000);
      end
      if (first_full == 0 && mask_o == 32'hFFFF_FFFF) first_full = i;
    end
    chk("R7", "steps to restore", first_full, 32'd40);
    chk("R7", "join pc", pc_o, 32'h17C);

    // Uniform branch landing on the join PC, both reconvergence actions
    cur_req = "R10";
    launch(32'h0000_00FF, 32'h0000_1000);
    branch(32'h0000_0003, 32'h0000_1100, 32'h0000_1200);
    branch(32'hFFFF_FFFF, 32'h0000_1200, 32'h0000_0000);
    chk("R10", "switch in branch cycle pc", pc_o, 32'h1004);
    chk("R10", "switch in branch cycle mask", mask_o, 32'h0000_00FC);
    branch(32'h0000_0000, 32'h0000_1200, 32'h0000_0000);
    chk("R10", "no-taken branch step", pc_o, 32'h1008);
    branch(32'hFFFF_FFFF, 32'h0000_1200, 32'h0000_0000);
    chk("R10", "pop in branch cycle", mask_o, 32'h0000_00FF);

    // Launch wins over a divergent branch in the same cycle
    cur_req = "R2";
    launch(32'hFFFF_FFFF, 32'h0000_2000);
    branch(32'h0000_0001, 32'h0000_2100, 32'h0000_2200);
    cyc(1, 32'h0000_0F0F, 32'h0000_3000, 1, 1, 32'h0000_0001, 32'h0000_3100, 32'h0000_3200);
    chk("R2", "launch over step mask", mask_o, 32'h0F0F);
    chk("R2", "launch over step split", {31'd0, split_o}, 32'd0);
    step();
    chk("R2", "stack cleared by launch", pc_o, 32'h3004);

    // Nesting to overflow
    cur_req = "R8";
    launch(32'hFFFF_FFFF, 32'h0000_4000);
    for (int k = 0; k < 9; k++) begin
      branch(~(32'd1 << k), 32'h0000_5000 + 32'(k * 16), 32'h0000_8000 + 32'(k * 256));
    end
    chk("R8", "overflow flag", {31'd0, ovf_o}, 32'd1);
    chk("R8", "mask held at overflow", mask_o, 32'hFFFF_FF00);
    step();
    chk("R8", "overflow sticky", {31'd0, ovf_o}, 32'd1);
    cur_req = "R2";
    launch(32'h0000_0001, 32'h0000_0000);
    chk("R2", "launch clears overflow", {31'd0, ovf_o}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule